// File: doc/BRIEF.md
# CPU Clock Stop and Frequency Switch Sequencer

This block runs the power-management handshakes for the clock of an attached processor. It performs two kinds of sequence. A stop sequence parks the processor, and a wake event later restarts it. A frequency-switch sequence changes the select lines that drive an external clock source. Each step of the handshake can be switched on or off by configuration inputs, so one block serves processors with different needs. These steps are: raising an active-low halt request, waiting for the processor to acknowledge it, and holding the request for a settle time after the change.

Configuration is captured when a sequence starts. While a sequence is running, any new request is ignored. A parked processor can only be restarted by a wake event. Settle times are counted in ticks of a 1 µs strobe input, so every hold time is an exact whole number of ticks. A one-cycle `done` pulse marks the end of each sequence.

Top module: `clkstop_seq`

## Requirements
- R1: After reset, `cpu_halt_n`=1, `clk_en`=1, `freq_sel`=FSEL_RESET, and `busy`, `stopped` and `done` are 0.
- R2: A stop request in idle with `stop_gate`=0, `stop_direct`=0 and `cfg_wait_halt_ack`=0 drives `cpu_halt_n` low, `stopped` high and `done` high after the next edge. `clk_en` stays 1 for the whole stop.
- R3: With `stop_gate`=1, the stop behaves as in R2, and in addition `clk_en` falls one cycle after `stopped` rises.
- R4: With `stop_direct`=1, the stop overrides `stop_gate` and `cfg_wait_halt_ack`. `stopped` rises after the next edge, `cpu_halt_n` stays 1, and `clk_en` falls one cycle later.
- R5: With `cfg_wait_halt_ack`=1 on a non-direct stop, `cpu_halt_n` falls and `busy` is 1 until `halt_ack` is sampled high. `stopped` and `done` rise after that edge.
- R6: `wake` has an effect only while `stopped`=1. After a stop with `stop_gate`=0, or a direct stop, one wake edge gives `clk_en`=1, `stopped`=0, `cpu_halt_n`=1 and `done`=1.
- R7: After a gated, non-direct stop, a wake edge sets `clk_en`=1 at once. `cpu_halt_n` then stays low until exactly N ticks of `us_tick` have been counted after the wake edge, where N comes from R10. It then rises together with `done`. When N=0 it rises on the wake edge.
- R8: A frequency request with `cfg_halt_on_switch`=0 loads `freq_target` into `freq_sel` after the next edge, pulses `done`, and never lowers `cpu_halt_n`.
- R9: A frequency request with `cfg_halt_on_switch`=1 lowers `cpu_halt_n` after the next edge. `freq_sel` changes one edge later, or one edge after `halt_ack` is sampled when `cfg_wait_halt_ack`=1. `cpu_halt_n` is then held for N ticks before it rises with `done`.
- R10: `cfg_settle_code` gives N in µs ticks: 0→0, 1→32, 2→64, 3→125, 4→250, 5→500, 6→1000, 7→2000. The code is captured when the request is accepted.
- R11: `stop_req` and `freq_req` are ignored while `busy` or `stopped` is 1. `wake` and `halt_ack` are ignored in idle. When `stop_req` and `freq_req` arrive in the same cycle, the stop is taken and `freq_sel` is left unchanged.
- R12: `done` is a one-cycle pulse and is never high while `busy` is 1.
- R13: `clk_en` changes only on an edge at which `stopped` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| stop_req | input | 1 | Request to park the processor |
| stop_gate | input | 1 | Gate the clock off during the stop |
| stop_direct | input | 1 | Gate the clock without a halt request |
| freq_req | input | 1 | Request a frequency switch |
| freq_target | input | FSEL_W | New frequency select value |
| wake | input | 1 | Wake event (restart) |
| halt_ack | input | 1 | Processor acknowledges the halt |
| cfg_halt_on_switch | input | 1 | Raise the halt request around a frequency switch |
| cfg_wait_halt_ack | input | 1 | Wait for `halt_ack` before continuing |
| cfg_settle_code | input | 3 | Settle-time code (R10) |
| cpu_halt_n | output | 1 | Halt request to the processor, active low, registered |
| clk_en | output | 1 | Clock gate enable |
| freq_sel | output | FSEL_W | Select lines to the clock source |
| busy | output | 1 | A sequence is in progress |
| stopped | output | 1 | The processor is parked |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
A wrong state code or a lost latched setting shows up at the ports one edge after the request or wake that uses it. The symptoms are a wrong level on `cpu_halt_n`, a `clk_en` that does not change, or `busy` and `stopped` flagging the wrong phase. A faulty settle timer shows up only when the hold ends, as a release of `cpu_halt_n` that comes one or more ticks early or late. For that reason the bench counts the strobes it drives between the wake or switch edge and the release, for every code. A sequencer that stalls in a waiting state is caught by `busy` staying high and `done` never arriving.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  localparam int SETTLE_W = 12;
  localparam int CODE_W   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STOP_ACK,
    ST_STOPPED,
    ST_WAKE_HOLD,
    ST_FREQ_ACK,
    ST_FREQ_SWITCH,
    ST_FREQ_HOLD
  } seq_state_e;

  // Settle time in microsecond ticks for a settle code.
  function automatic logic [SETTLE_W-1:0] settle_us_f(input logic [CODE_W-1:0] code);
    logic [SETTLE_W-1:0] r;
    case (code)
      3'd0:    r = 12'd0;
      3'd1:    r = 12'd32;
      3'd2:    r = 12'd64;
      3'd3:    r = 12'd125;
      3'd4:    r = 12'd250;
      3'd5:    r = 12'd500;
      3'd6:    r = 12'd1000;
      default: r = 12'd2000;
    endcase
    return r;
  endfunction

  function automatic logic settle_is_zero_f(input logic [CODE_W-1:0] code);
    return settle_us_f(code) == '0;
  endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/freq_latch.sv
module freq_latch #(
  parameter int          W         = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VAL;
    else if (capture) q <= d;
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import clkstop_pkg::*;
#(
  parameter int FSEL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_req,
  input  logic                stop_gate,
  input  logic                stop_direct,
  input  logic                freq_req,
  input  logic [FSEL_W-1:0]   freq_target,
  input  logic                wake,
  input  logic                halt_ack,
  input  logic                cfg_halt_on_switch,
  input  logic                cfg_wait_halt_ack,
  input  logic [CODE_W-1:0]   cfg_settle_code,
  input  logic                timer_zero,
  output seq_state_e          state,
  output logic                cpu_halt_n,
  output logic                clk_en,
  output logic                done,
  output logic                timer_load,
  output logic [SETTLE_W-1:0] timer_val,
  output logic                fsel_load,
  output logic [FSEL_W-1:0]   fsel_val
);
  seq_state_e        nxt;
  logic              halt_n_nxt, clk_en_nxt, done_nxt;
  logic              lat_gate, lat_direct;
  logic [CODE_W-1:0] lat_code;
  logic [FSEL_W-1:0] lat_target;
  logic              lat_zero;

  assign lat_zero  = settle_is_zero_f(lat_code);
  assign timer_val = settle_us_f(lat_code);

  always_comb begin
    nxt        = state;
    halt_n_nxt = cpu_halt_n;
    clk_en_nxt = clk_en;
    done_nxt   = 1'b0;
    timer_load = 1'b0;
    fsel_load  = 1'b0;
    fsel_val   = lat_target;
    unique case (state)
      ST_IDLE: begin
        if (stop_req) begin
          if (stop_direct) begin
            nxt      = ST_STOPPED;
            done_nxt = 1'b1;
          end else begin
            halt_n_nxt = 1'b0;
            if (cfg_wait_halt_ack) begin
              nxt = ST_STOP_ACK;
            end else begin
              nxt      = ST_STOPPED;
              done_nxt = 1'b1;
            end
          end
        end else if (freq_req) begin
          if (!cfg_halt_on_switch) begin
            fsel_load = 1'b1;
            fsel_val  = freq_target;
            done_nxt  = 1'b1;
          end else begin
            halt_n_nxt = 1'b0;
            nxt        = cfg_wait_halt_ack ? ST_FREQ_ACK : ST_FREQ_SWITCH;
          end
        end
      end
      ST_STOP_ACK: begin
        if (halt_ack) begin
          nxt      = ST_STOPPED;
          done_nxt = 1'b1;
        end
      end
      ST_STOPPED: begin
        if (wake) begin
          clk_en_nxt = 1'b1;
          if (lat_direct) begin
            nxt      = ST_IDLE;
            done_nxt = 1'b1;
          end else if (lat_gate && !lat_zero) begin
            nxt        = ST_WAKE_HOLD;
            timer_load = 1'b1;
          end else begin
            halt_n_nxt = 1'b1;
            nxt        = ST_IDLE;
            done_nxt   = 1'b1;
          end
        end else begin
          clk_en_nxt = !(lat_gate || lat_direct);
        end
      end
      ST_WAKE_HOLD, ST_FREQ_HOLD: begin
        if (timer_zero) begin
          halt_n_nxt = 1'b1;
          nxt        = ST_IDLE;
          done_nxt   = 1'b1;
        end
      end
      ST_FREQ_ACK: begin
        if (halt_ack) nxt = ST_FREQ_SWITCH;
      end
      ST_FREQ_SWITCH: begin
        fsel_load = 1'b1;
        if (lat_zero) begin
          halt_n_nxt = 1'b1;
          nxt        = ST_IDLE;
          done_nxt   = 1'b1;
        end else begin
          timer_load = 1'b1;
          nxt        = ST_FREQ_HOLD;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cpu_halt_n <= 1'b1;
      clk_en     <= 1'b1;
      done       <= 1'b0;
      lat_gate   <= 1'b0;
      lat_direct <= 1'b0;
      lat_code   <= '0;
      lat_target <= '0;
    end else begin
      state      <= nxt;
      cpu_halt_n <= halt_n_nxt;
      clk_en     <= clk_en_nxt;
      done       <= done_nxt;
      if (state == ST_IDLE) begin
        lat_gate   <= stop_gate;
        lat_direct <= stop_direct;
        lat_code   <= cfg_settle_code;
        lat_target <= freq_target;
      end
    end
  end
endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq
  import clkstop_pkg::*;
#(
  parameter int                FSEL_W     = 2,
  parameter logic [FSEL_W-1:0] FSEL_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              stop_req,
  input  logic              stop_gate,
  input  logic              stop_direct,
  input  logic              freq_req,
  input  logic [FSEL_W-1:0] freq_target,
  input  logic              wake,
  input  logic              halt_ack,
  input  logic              cfg_halt_on_switch,
  input  logic              cfg_wait_halt_ack,
  input  logic [2:0]        cfg_settle_code,
  output logic              cpu_halt_n,
  output logic              clk_en,
  output logic [FSEL_W-1:0] freq_sel,
  output logic              busy,
  output logic              stopped,
  output logic              done
);
  seq_state_e          state;
  logic                timer_load, timer_zero, fsel_load;
  logic [SETTLE_W-1:0] timer_val;
  logic [FSEL_W-1:0]   fsel_val;

  // Named internal events for the checker
  logic in_idle, hold_active;
  assign in_idle     = (state == ST_IDLE);
  assign hold_active = (state == ST_WAKE_HOLD) || (state == ST_FREQ_HOLD);

  assign stopped = (state == ST_STOPPED);
  assign busy    = !in_idle && !stopped;

  seq_fsm #(.FSEL_W(FSEL_W)) u_fsm (
    .clk                (clk),
    .rst_n              (rst_n),
    .stop_req           (stop_req),
    .stop_gate          (stop_gate),
    .stop_direct        (stop_direct),
    .freq_req           (freq_req),
    .freq_target        (freq_target),
    .wake               (wake),
    .halt_ack           (halt_ack),
    .cfg_halt_on_switch (cfg_halt_on_switch),
    .cfg_wait_halt_ack  (cfg_wait_halt_ack),
    .cfg_settle_code    (cfg_settle_code),
    .timer_zero         (timer_zero),
    .state              (state),
    .cpu_halt_n         (cpu_halt_n),
    .clk_en             (clk_en),
    .done               (done),
    .timer_load         (timer_load),
    .timer_val          (timer_val),
    .fsel_load          (fsel_load),
    .fsel_val           (fsel_val)
  );

  settle_timer #(.W(SETTLE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .tick     (us_tick),
    .zero     (timer_zero)
  );

  freq_latch #(.W(FSEL_W), .RESET_VAL(FSEL_RESET)) u_fsel (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (fsel_load),
    .d       (fsel_val),
    .q       (freq_sel)
  );
endmodule

// File: rtl/clkstop_seq_chk.sv
module clkstop_seq_chk #(
  parameter int FSEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_req,
  input logic              freq_req,
  input logic              wake,
  input logic              halt_ack,
  input logic              cpu_halt_n,
  input logic              clk_en,
  input logic [FSEL_W-1:0] freq_sel,
  input logic              busy,
  input logic              stopped,
  input logic              done,
  input logic              in_idle,
  input logic              hold_active,
  input logic              timer_zero
);
  // R13
  clk_en_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_en) |-> $past(stopped));

  // R12
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  idle_wake_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && (wake || halt_ack) && !stop_req && !freq_req) |=>
      (in_idle && $stable(cpu_halt_n) && $stable(clk_en) && $stable(freq_sel) && !done));

  // R10
  release_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_halt_n) |-> $past(timer_zero));

  // R5
  stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> ($past(stop_req) || $past(halt_ack)));

  // R9
  fsel_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_sel) |-> (busy || done));

  // R7
  hold_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> (!cpu_halt_n && clk_en));
endmodule

bind clkstop_seq clkstop_seq_chk #(.FSEL_W(FSEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_req    (stop_req),
  .freq_req    (freq_req),
  .wake        (wake),
  .halt_ack    (halt_ack),
  .cpu_halt_n  (cpu_halt_n),
  .clk_en      (clk_en),
  .freq_sel    (freq_sel),
  .busy        (busy),
  .stopped     (stopped),
  .done        (done),
  .in_idle     (in_idle),
  .hold_active (hold_active),
  .timer_zero  (timer_zero)
);

// File: tb/clkstop_seq_test.sv
module clkstop_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 2;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0;
  logic stop_req = 0, stop_gate = 0, stop_direct = 0, freq_req = 0;
  logic [FW-1:0] freq_target = '0;
  logic wake = 0, halt_ack = 0, cfg_halt_on_switch = 0, cfg_wait_halt_ack = 0;
  logic [2:0] cfg_settle_code = '0;
  logic cpu_halt_n, clk_en, busy, stopped, done;
  logic [FW-1:0] freq_sel;

  int checks = 0, errors = 0;
  bit tick_force = 0, finished = 0;
  logic [FW-1:0] exp_fsel = '0;

  clkstop_seq #(.FSEL_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .stop_req(stop_req),
    .stop_gate(stop_gate), .stop_direct(stop_direct), .freq_req(freq_req),
    .freq_target(freq_target), .wake(wake), .halt_ack(halt_ack),
    .cfg_halt_on_switch(cfg_halt_on_switch), .cfg_wait_halt_ack(cfg_wait_halt_ack),
    .cfg_settle_code(cfg_settle_code), .cpu_halt_n(cpu_halt_n), .clk_en(clk_en),
    .freq_sel(freq_sel), .busy(busy), .stopped(stopped), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    us_tick <= tick_force ? 1'b1 : (($urandom % 4) != 0);
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Settle ticks restated as shifted bases
  function automatic int exp_ticks(input logic [2:0] c);
    if (c == 0) return 0;
    if (c <= 2) return 32 << (c - 1);
    if (c <= 5) return 125 << (c - 3);
    return 1000 << (c - 6);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_hold(input int n, input string req);
    int seen = 0;
    int guard = 0;
    logic t;
    forever begin
      @(posedge clk);
      t = us_tick;
      @(negedge clk);
      if (cpu_halt_n) break;
      if (t) seen++;
      guard++;
      if (guard > 20000) break;
    end
    chk({req, " hold ticks"}, seen, n);
    chk({req, " done at release"}, done, 1);
    chk({req, " idle after release"}, busy, 0);
  endtask

  task automatic do_stop(input bit gate, input bit direct, input bit wait_ack, input logic [2:0] code);
    stop_gate = gate; stop_direct = direct; cfg_wait_halt_ack = wait_ack; cfg_settle_code = code;
    stop_req = 1; @(negedge clk); stop_req = 0;
    if (wait_ack && !direct) begin
      chk("R5 halt low while waiting", cpu_halt_n, 0);
      chk("R5 not stopped before ack", stopped, 0);
      chk("R5 busy while waiting", busy, 1);
      freq_target = ~exp_fsel; freq_req = 1; @(negedge clk); freq_req = 0;
      chk("R11 freq_req ignored while busy", freq_sel, exp_fsel);
      cyc(1);
      halt_ack = 1; @(negedge clk); halt_ack = 0;
    end
    chk("R2 stopped after stop", stopped, 1);
    chk("R12 done at stop end", done, 1);
    chk(direct ? "R4 halt untouched" : "R2 halt asserted", cpu_halt_n, direct ? 1 : 0);
    chk("R13 clk_en unchanged on entry", clk_en, 1);
    cyc(1);
    chk(direct ? "R4 clock gated" : (gate ? "R3 clock gated" : "R2 clock running"),
        clk_en, (gate || direct) ? 0 : 1);
    chk("R12 done one cycle", done, 0);
    stop_req = 1; freq_target = ~exp_fsel; freq_req = 1; @(negedge clk);
    stop_req = 0; freq_req = 0;
    chk("R11 requests ignored while stopped", stopped, 1);
    chk("R11 freq kept while stopped", freq_sel, exp_fsel);
  endtask

  task automatic do_wake(input bit gate, input bit direct, input logic [2:0] code);
    int n = exp_ticks(code);
    wake = 1; @(negedge clk); wake = 0;
    chk("R6 clock enabled on wake", clk_en, 1);
    chk("R6 not stopped after wake", stopped, 0);
    if (gate && !direct && n != 0) begin
      chk("R7 halt held after wake", cpu_halt_n, 0);
      count_hold(n, "R7");
    end else begin
      chk("R6 halt released", cpu_halt_n, 1);
      chk("R6 done on restart", done, 1);
    end
  endtask

  task automatic do_freq(input logic [FW-1:0] tgt, input bit assert_h, input bit wait_ack, input logic [2:0] code);
    int n = exp_ticks(code);
    cfg_halt_on_switch = assert_h; cfg_wait_halt_ack = wait_ack; cfg_settle_code = code;
    freq_target = tgt; freq_req = 1; @(negedge clk); freq_req = 0;
    if (!assert_h) begin
      exp_fsel = tgt;
      chk("R8 freq switched at once", freq_sel, exp_fsel);
      chk("R8 halt untouched", cpu_halt_n, 1);
      chk("R8 done", done, 1);
      return;
    end
    chk("R9 halt asserted", cpu_halt_n, 0);
    chk("R9 freq not yet switched", freq_sel, exp_fsel);
    if (wait_ack) begin
      wake = 1; stop_req = 1; @(negedge clk); wake = 0; stop_req = 0;
      chk("R11 wake ignored in switch", clk_en, 1);
      chk("R11 still busy", busy, 1);
      chk("R9 freq held before ack", freq_sel, exp_fsel);
      halt_ack = 1; @(negedge clk); halt_ack = 0;
      chk("R9 freq unchanged on ack edge", freq_sel, exp_fsel);
    end
    @(negedge clk);
    exp_fsel = tgt;
    chk("R9 freq switched", freq_sel, exp_fsel);
    if (n == 0) begin
      chk("R10 zero code releases", cpu_halt_n, 1);
      chk("R9 done", done, 1);
    end else begin
      chk("R9 halt held after switch", cpu_halt_n, 0);
      count_hold(n, "R9/R10");
    end
  endtask

  initial begin
    int junk;
    junk = $urandom(32'd2024);
    cyc(3);
    chk("R1 halt", cpu_halt_n, 1);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 freq", freq_sel, 0);
    chk("R1 status", {busy, stopped, done}, 0);
    rst_n = 1; cyc(2);

    // idle noise
    wake = 1; halt_ack = 1; @(negedge clk); wake = 0; halt_ack = 0;
    chk("R11 wake in idle", {busy, stopped, done, clk_en, cpu_halt_n}, 5'b00011);

    do_stop(0, 0, 0, 3'd3); do_wake(0, 0, 3'd3);
    do_stop(1, 0, 0, 3'd3); do_wake(1, 0, 3'd3);
    do_stop(1, 0, 1, 3'd0); do_wake(1, 0, 3'd0);
    do_stop(1, 1, 1, 3'd5); do_wake(1, 1, 3'd5);
    do_freq(2'd2, 0, 0, 3'd4);
    do_freq(2'd1, 1, 1, 3'd1);

    // R11 priority: stop wins over freq
    stop_gate = 0; stop_direct = 0; cfg_wait_halt_ack = 0;
    freq_target = ~exp_fsel; cfg_halt_on_switch = 0;
    stop_req = 1; freq_req = 1; @(negedge clk); stop_req = 0; freq_req = 0;
    chk("R11 stop wins", stopped, 1);
    chk("R11 freq untouched", freq_sel, exp_fsel);
    do_wake(0, 0, 3'd0);

    // R10: every settle code with a tick on each cycle
    tick_force = 1;
    for (int c = 0; c < 8; c++) begin
      do_freq(FW'(c), 1, c[0], 3'(c));
      cyc(1);
    end
    tick_force = 0;

    for (int i = 0; i < 25; i++) begin
      int op = $urandom % 3;
      logic [2:0] code = 3'($urandom % 6);
      if (op == 0) begin
        bit g = $urandom % 2, d = ($urandom % 4) == 0, w = $urandom % 2;
        do_stop(g, d, w, code); cyc($urandom % 3); do_wake(g, d, code);
      end else if (op == 1) begin
        do_freq(FW'($urandom), $urandom % 2, $urandom % 2, code);
      end else begin
        wake = 1; @(negedge clk); wake = 0;
        chk("R11 random idle wake", {busy, stopped, cpu_halt_n}, 3'b001);
      end
      cyc(1);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule